// File: doc/BRIEF.md
# Table-Driven Page Translation Unit

This unit turns a virtual address and an address-space identifier into a physical address. All translations live in an on-chip mapping RAM holding one physical page number per (address space, virtual page) pair. No walk of main memory ever happens. The page offset passes through untouched. The translation port is pipelined: a request presented in one cycle returns its physical address in the next.

The same mapping RAM is reachable through a simple request/acknowledge register port, which software uses to read and write entries. The top five virtual pages of every address space are not stored in the RAM. A small constant table supplies them from reset, and they point at the mapping table's own pages and the boot ROM, so both stay reachable before software has built any map. Writes aimed at those five slots are acknowledged and discarded.

The register port is sequenced by a three-state machine with states `ST_IDLE`, `ST_WR_ACK` and `ST_RD_ACK`:
- `ST_IDLE` moves to `ST_WR_ACK` on an accepted write and to `ST_RD_ACK` on an accepted read. A request is accepted only when `io_req` is high and no translation is presented in that cycle.
- `ST_WR_ACK` and `ST_RD_ACK` both return to `ST_IDLE` unconditionally.
- Translation requests always win the shared RAM port.

Top module: `pgmap_mmu`

## Requirements
- R1: `lk_rvalid` is high exactly in the cycle after a cycle with `lk_valid` high, and is low after reset.
- R2: The returned `lk_paddr` is {PPN, `lk_vaddr[15:0]`}. The PPN is the entry at index {`lk_asid`, `lk_vaddr[25:16]`}. Bits `lk_vaddr[31:26]` have no effect on the result.
- R3: Entries of different address spaces are independent: a write to one space's page leaves the same page of every other space unchanged.
- R4: In every address space, virtual pages 1019, 1020, 1021, 1022 and 1023 translate from reset to PPNs 0x1F00, 0x1F01, 0x1FFD, 0x1FFE and 0x1FFF respectively. The first two are the mapping-table pages and the last three are the ROM pages.
- R5: A register-port write to a page in 1019..1023 of any address space is acknowledged but leaves that entry's translation and read-back value unchanged.
- R6: An accepted register-port write (`io_we`=1) stores `io_wdata` at `io_idx`. `io_idx` is {asid, vpn}. `io_ack` is high in the cycle right after acceptance.
- R7: An accepted register-port read (`io_we`=0) drives the entry's PPN on `io_rdata` in the cycle right after acceptance, together with `io_ack`.
- R8: A register-port request is never accepted in a cycle where `lk_valid` is high. `io_ack` therefore only follows a cycle with `io_req` high and `lk_valid` low.
- R9: `io_ack` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Translation request strobe |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_rvalid | output | 1 | Translation result valid |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| io_req | input | 1 | Register-port request, held until acknowledged |
| io_we | input | 1 | 1 = write entry, 0 = read entry |
| io_idx | input | ASID_W+VPN_W | Entry index {asid, vpn} |
| io_wdata | input | PPN_W | PPN to store |
| io_ack | output | 1 | Register-port acknowledge pulse |
| io_rdata | output | PPN_W | PPN read back, valid with a read acknowledge |

## Verification
Translations are tried with random offsets and random upper address bits. A wrong index slice or a dropped offset shows up as a wrong physical address. Pairs of writes to the same page in different address spaces distinguish a truly per-space index from one that drops the identifier. Writes aimed at the five top pages, followed by read-back and translation, separate real write protection from a preset that merely starts right. Requests that collide with translations in the same cycle confirm that translations keep the RAM port, and that a held register request completes one cycle after the collision clears.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    // Sequencing of the register port
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WR_ACK = 2'd1,
        ST_RD_ACK = 2'd2
    } io_state_e;

endpackage

// File: rtl/pgmap_io_fsm.sv
module pgmap_io_fsm
    import pgmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic io_req,
    input  logic io_we,
    input  logic lk_busy,
    output logic take,
    output logic wr_take,
    output logic io_ack
);

    io_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (io_req && !lk_busy)
                    state_d = io_we ? ST_WR_ACK : ST_RD_ACK;
            end
            ST_WR_ACK: state_d = ST_IDLE;
            ST_RD_ACK: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take    = 1'b0;
        wr_take = 1'b0;
        io_ack  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take    = io_req && !lk_busy;
                wr_take = io_req && !lk_busy && io_we;
            end
            ST_WR_ACK: io_ack = 1'b1;
            ST_RD_ACK: io_ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pgmap_preset.sv
module pgmap_preset #(
    parameter int VPN_W = 10,
    parameter int PPN_W = 13,
    parameter int N_TBL = 2,
    parameter int N_ROM = 3,
    parameter logic [PPN_W-1:0] TBL_BASE = 'h1F00,
    parameter logic [PPN_W-1:0] ROM_BASE = 'h1FFD
) (
    input  logic [VPN_W-1:0] vpn,
    output logic             prot,
    output logic [PPN_W-1:0] ppn
);

    localparam int N_PROT = N_TBL + N_ROM;
    localparam int SLOT_W = (N_PROT > 1) ? $clog2(N_PROT) : 1;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGES  = 1 << VPN_W;
    localparam int FIRST  = PAGES - N_PROT;

    logic [PPN_W-1:0]  slot_ppn [SLOTS];
    logic [SLOT_W-1:0] rel;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k < N_TBL) begin : g_tbl
            assign slot_ppn[k] = TBL_BASE + PPN_W'(k);
        end else if (k < N_PROT) begin : g_rom
            assign slot_ppn[k] = ROM_BASE + PPN_W'(k - N_TBL);
        end else begin : g_pad
            assign slot_ppn[k] = '0;
        end
    end

    assign rel  = SLOT_W'(vpn - VPN_W'(FIRST));
    assign prot = (vpn >= VPN_W'(FIRST));
    assign ppn  = prot ? slot_ppn[rel] : '0;

endmodule

// File: rtl/pgmap_ram.sv
module pgmap_ram #(
    parameter int AW = 12,
    parameter int DW = 13
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        q <= mem[addr];
    end

endmodule

// File: rtl/pgmap_mmu.sv
module pgmap_mmu #(
    parameter int ASID_W = 2,
    parameter int VPN_W  = 10,
    parameter int OFF_W  = 16,
    parameter int PPN_W  = 13,
    parameter int VA_W   = 32,
    parameter int N_TBL  = 2,
    parameter int N_ROM  = 3,
    parameter logic [PPN_W-1:0] TBL_BASE = 'h1F00,
    parameter logic [PPN_W-1:0] ROM_BASE = 'h1FFD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lk_valid,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [VA_W-1:0]         lk_vaddr,
    output logic                    lk_rvalid,
    output logic [PPN_W+OFF_W-1:0]  lk_paddr,
    input  logic                    io_req,
    input  logic                    io_we,
    input  logic [ASID_W+VPN_W-1:0] io_idx,
    input  logic [PPN_W-1:0]        io_wdata,
    output logic                    io_ack,
    output logic [PPN_W-1:0]        io_rdata
);

    localparam int IDX_W = ASID_W + VPN_W;
    localparam int VPN_HI = OFF_W + VPN_W - 1;

    logic [IDX_W-1:0] ram_addr;
    logic [PPN_W-1:0] ram_q;
    logic             ram_we;
    logic             take, wr_take;
    logic             prot, prot_q;
    logic [PPN_W-1:0] pre_ppn, pre_q;
    logic [OFF_W-1:0] off_q;
    logic [PPN_W-1:0] ppn_out;
    logic             unused_vahi;

    assign unused_vahi = ^lk_vaddr[VA_W-1:VPN_HI+1];

    // Translations own the RAM port whenever present
    assign ram_addr = lk_valid ? {lk_asid, lk_vaddr[VPN_HI:OFF_W]} : io_idx;

    pgmap_io_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .io_req  (io_req),
        .io_we   (io_we),
        .lk_busy (lk_valid),
        .take    (take),
        .wr_take (wr_take),
        .io_ack  (io_ack)
    );

    pgmap_preset #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .N_TBL(N_TBL), .N_ROM(N_ROM),
        .TBL_BASE(TBL_BASE), .ROM_BASE(ROM_BASE)
    ) u_preset (
        .vpn  (ram_addr[VPN_W-1:0]),
        .prot (prot),
        .ppn  (pre_ppn)
    );

    assign ram_we = wr_take && !prot;

    pgmap_ram #(.AW(IDX_W), .DW(PPN_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (io_wdata),
        .q     (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rvalid <= 1'b0;
            prot_q    <= 1'b0;
            pre_q     <= '0;
            off_q     <= '0;
        end else begin
            lk_rvalid <= lk_valid;
            prot_q    <= prot;
            pre_q     <= pre_ppn;
            off_q     <= lk_vaddr[OFF_W-1:0];
        end
    end

    assign ppn_out  = prot_q ? pre_q : ram_q;
    assign lk_paddr = {ppn_out, off_q};
    assign io_rdata = ppn_out;

    logic unused_take;
    assign unused_take = take;

endmodule

// File: rtl/pgmap_mmu_chk.sv
module pgmap_mmu_chk #(
    parameter int ASID_W = 2,
    parameter int VPN_W  = 10,
    parameter int OFF_W  = 16,
    parameter int PPN_W  = 13,
    parameter int VA_W   = 32,
    parameter int N_ROM  = 3,
    parameter logic [PPN_W-1:0] ROM_BASE = 'h1FFD
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    lk_valid,
    input logic [VA_W-1:0]         lk_vaddr,
    input logic                    lk_rvalid,
    input logic [PPN_W+OFF_W-1:0]  lk_paddr,
    input logic                    io_req,
    input logic                    io_ack
);

    localparam int PA_W = PPN_W + OFF_W;

    a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_rvalid);

    a_r1_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_rvalid);

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    a_r4_top_page_rom: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && (lk_vaddr[OFF_W+VPN_W-1:OFF_W] == '1)) |=>
        (lk_paddr[PA_W-1:OFF_W] == ROM_BASE + PPN_W'(N_ROM - 1)));

    a_r8_ack_source: assert property (@(posedge clk) disable iff (rst)
        io_ack |-> $past(io_req && !lk_valid));

    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        io_ack |=> !io_ack);

endmodule

bind pgmap_mmu pgmap_mmu_chk #(
    .ASID_W(ASID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .VA_W(VA_W), .N_ROM(N_ROM), .ROM_BASE(ROM_BASE)
) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_rvalid(lk_rvalid), .lk_paddr(lk_paddr),
    .io_req(io_req), .io_ack(io_ack)
);

// File: tb/pgmap_mmu_tb.sv
`timescale 1ns/1ps
module pgmap_mmu_tb;

    localparam int ASID_W = 2;
    localparam int VPN_W  = 10;
    localparam int IDX_W  = ASID_W + VPN_W;
    localparam int NENT   = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_asid = '0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_rvalid;
    logic [28:0] lk_paddr;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [11:0] io_idx = '0;
    logic [12:0] io_wdata = '0;
    logic        io_ack;
    logic [12:0] io_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [12:0] model [NENT];
    bit          known [NENT];

    always #4 clk = ~clk;

    pgmap_mmu u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
        .lk_rvalid(lk_rvalid), .lk_paddr(lk_paddr),
        .io_req(io_req), .io_we(io_we), .io_idx(io_idx),
        .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
    );

    function automatic bit is_prot(input logic [9:0] vpn);
        return vpn >= 10'd1019;
    endfunction

    function automatic logic [12:0] preset_of(input logic [9:0] vpn);
        case (vpn)
            10'd1019: return 13'h1F00;
            10'd1020: return 13'h1F01;
            10'd1021: return 13'h1FFD;
            10'd1022: return 13'h1FFE;
            default:  return 13'h1FFF;
        endcase
    endfunction

    function automatic logic [12:0] expect_ppn(input logic [11:0] idx);
        if (is_prot(idx[9:0])) return preset_of(idx[9:0]);
        return model[idx];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [11:0] idx, input logic [12:0] d);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b1; io_idx = idx; io_wdata = d;
        @(negedge clk);
        check("R6 write ack", {31'd0, io_ack}, 32'd1);
        io_req = 1'b0; io_we = 1'b0;
        if (!is_prot(idx[9:0])) begin
            model[idx] = d; known[idx] = 1'b1;
        end
        @(negedge clk);
        check("R9 ack pulse", {31'd0, io_ack}, 32'd0);
    endtask

    task automatic io_read(input logic [11:0] idx, input string req);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b0; io_idx = idx;
        @(negedge clk);
        check("R7 read ack", {31'd0, io_ack}, 32'd1);
        check(req, {19'd0, io_rdata}, {19'd0, expect_ppn(idx)});
        io_req = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] asid, input logic [31:0] va, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = asid; lk_vaddr = va;
        @(negedge clk);
        check("R1 rvalid", {31'd0, lk_rvalid}, 32'd1);
        check(req, {3'd0, lk_paddr}, {3'd0, expect_ppn({asid, va[25:16]}), va[15:0]});
        lk_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NENT; i++) known[i] = 1'b0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1 reset rvalid", {31'd0, lk_rvalid}, 32'd0);
        check("R9 reset ack", {31'd0, io_ack}, 32'd0);

        // R4: presets in every address space, via both ports
        for (int a = 0; a < 4; a++) begin
            for (int v = 1019; v < 1024; v++) begin
                io_read({a[1:0], v[9:0]}, "R4 preset readback");
                lookup(a[1:0], {6'h2A, v[9:0], 16'h1234}, "R4 preset translate");
            end
        end

        // R5: writes to protected pages are dropped
        for (int v = 1019; v < 1024; v++) begin
            io_write({2'd2, v[9:0]}, 13'h0ABC);
            io_read({2'd2, v[9:0]}, "R5 protected readback");
            lookup(2'd2, {6'h00, v[9:0], 16'hBEEF}, "R5 protected translate");
        end

        // R3: same page, different spaces
        io_write({2'd0, 10'd5}, 13'h0111);
        io_write({2'd1, 10'd5}, 13'h0222);
        io_write({2'd3, 10'd5}, 13'h0333);
        lookup(2'd0, {6'h3F, 10'd5, 16'h0001}, "R3 space 0");
        lookup(2'd1, {6'h00, 10'd5, 16'hFFFF}, "R3 space 1");
        lookup(2'd3, {6'h15, 10'd5, 16'h8000}, "R3 space 3");
        io_read({2'd1, 10'd5}, "R3 readback");

        // R8: collision, translation keeps the port, request completes after
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b0; io_idx = {2'd0, 10'd5};
        lk_valid = 1'b1; lk_asid = 2'd3; lk_vaddr = {6'h01, 10'd5, 16'h4321};
        @(negedge clk);
        check("R8 no ack while translating", {31'd0, io_ack}, 32'd0);
        check("R8 translation wins", {3'd0, lk_paddr}, {3'd0, 13'h0333, 16'h4321});
        lk_valid = 1'b0;
        @(negedge clk);
        check("R8 deferred ack", {31'd0, io_ack}, 32'd1);
        check("R8 deferred data", {19'd0, io_rdata}, 32'h0111);
        io_req = 1'b0;
        @(negedge clk);
        check("R1 rvalid drops", {31'd0, lk_rvalid}, 32'd0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            automatic int op = $urandom % 4;
            automatic logic [11:0] idx = 12'($urandom);
            if (op <= 1) begin
                if ($urandom % 8 == 0) idx[9:0] = 10'd1019 + 10'($urandom % 5);
                io_write(idx, 13'($urandom));
            end else if (op == 2) begin
                if (known[idx] || is_prot(idx[9:0])) io_read(idx, "R7 random readback");
            end else begin
                if (known[idx] || is_prot(idx[9:0]))
                    lookup(idx[11:10], {6'($urandom), idx[9:0], 16'($urandom)}, "R2 random translate");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule